// File: doc/BRIEF.md
# Dual-Speed Processor Clock Controller

This block generates the processor phase clock for a system whose processor and video logic share one memory bus. The master clock is divided into 1 MHz bus slots of eight master cycles. In a slow slot the first half belongs to the video side and the second half to the processor, and the phase clock runs at 1 MHz. In a fast slot the phase clock runs at 2 MHz and the processor holds the bus for the whole slot. A mode bit in a small register selects fast operation. Setting that bit also switches the display off.

Even in fast mode, some slots stay slow. A slot that carries a DRAM refresh access is always slow, and so is a slot that begins while the processor is selecting I/O. The slot type is chosen only at a slot boundary, so the phase clock never has a half-period shorter than two master cycles.

A line strobe arms five refresh accesses. Each one takes the video half of a slow slot. An 8-bit row counter supplies the refresh address. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `dsc_clock_ctl`

## Requirements
- R1: After reset the mode bit is 0, `display_en` is 1, `rd_data` reads 8'hFE, `ref_addr` is 0, `ref_act` is 0, and the first slot is slow.
- R2: In a slow slot, `phi0` is low for master cycles 0–3 of the slot and high for cycles 4–7. `cpu_bus` equals `phi0`.
- R3: In a fast slot, `phi0` is low for 2 cycles, then high for 2, and repeats (low at cycles 0,1,4,5 and high at 2,3,6,7). `cpu_bus` is 1 for the whole slot.
- R4: A write with `wr_addr` = 48 stores `wr_data[0]` as the mode bit (1 = fast). `rd_data` is {7'b1111111, mode}. A write to any other address leaves the mode bit unchanged.
- R5: `display_en` is the inverse of the mode bit and changes in the cycle after the write edge.
- R6: The slot type is fixed at the slot boundary, where cycle 7 wraps to 0. A mode change first affects the slot that starts after the next boundary.
- R7: If `io_sel` is 1 in cycle 7 of a slot, the next slot is not fast, whatever the mode bit is.
- R8: A one-cycle `line_stb` arms 5 refresh accesses. Each of the next 5 slots after that is a refresh slot, in either mode. A refresh slot has slow timing, `ref_act` is 1 in its cycles 0–3, and `cpu_bus` is 0 while `ref_act` is 1.
- R9: `ref_addr` is the row refreshed in the current refresh slot. It advances by one at the end of each refresh slot and wraps from 255 to 0.
- R10: Every high and every low phase of `phi0` lasts at least 2 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (8 × the slow phase rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Readback of the mode register |
| line_stb | input | 1 | Raster line strobe; arms the refresh burst |
| io_sel | input | 1 | Processor I/O access in progress |
| phi0 | output | 1 | Processor phase clock |
| cpu_bus | output | 1 | 1 while the processor owns the shared bus |
| display_en | output | 1 | Video display enable |
| ref_act | output | 1 | DRAM refresh access in progress |
| ref_addr | output | 8 | DRAM refresh row |

## Verification
The embedded assertions check on every cycle that:
- `phi0` never holds a level for only one master cycle;
- a refresh access never overlaps processor bus ownership;
- an I/O select seen at a boundary never yields a fast slot;
- the slot type stays fixed inside a slot;
- each completed refresh slot moves the row by exactly one.

Only the bench's scenarios can show the rest. These are the exact phase patterns of slow, fast and refresh slots, the one-slot lag between a mode write and its effect, the rejection of writes to other addresses, and the row counter wrapping after more than 256 refreshes spread across many lines.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    SLOT_SLOW    = 2'd0,
    SLOT_FAST    = 2'd1,
    SLOT_REFRESH = 2'd2
  } slot_e;
endpackage

// File: rtl/dsc_phase.sv
module dsc_phase #(
  parameter int PH_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PH_BITS-1:0] ph,
  output logic               slot_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + 1'b1;
  end

  assign slot_end = &ph;

  // R6: the phase wraps to zero right after the final slot cycle
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (ph == '0));
endmodule

// File: rtl/dsc_mode_reg.sv
module dsc_mode_reg #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int MODE_ADR = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fast_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] ADR = ADDR_W'(MODE_ADR);

  logic hit;
  logic unused_hi;

  assign hit       = wr_en && (wr_addr == ADR);
  assign unused_hi = ^wr_data[DATA_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fast_q <= 1'b0;
    else if (hit) fast_q <= wr_data[0];
  end

  assign rd_data = {{(DATA_W-1){1'b1}}, fast_q};

  // R4: a write to another address leaves the mode bit alone
  assert_foreign_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADR) |=> $stable(fast_q));
endmodule

// File: rtl/dsc_refresh.sv
module dsc_refresh #(
  parameter int ROW_W    = 8,
  parameter int PER_LINE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             slot_end,
  input  logic             in_ref_slot,
  output logic             take,
  output logic [ROW_W-1:0] row
);
  localparam int PW = $clog2(PER_LINE + 1);
  localparam logic [PW-1:0] LOAD = PW'(PER_LINE);

  logic [PW-1:0] pend;

  assign take = slot_end && (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      row  <= '0;
    end else begin
      if (line_stb)  pend <= LOAD;
      else if (take) pend <= pend - 1'b1;
      if (slot_end && in_ref_slot) row <= row + 1'b1;
    end
  end

  // R8: the pending count never exceeds the per-line burst
  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= LOAD);

  // R9: each finished refresh slot moves the row by exactly one
  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && in_ref_slot) |=> (row == ROW_W'($past(row) + 1'b1)));
endmodule

// File: rtl/dsc_slot_sel.sv
module dsc_slot_sel
  import dsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_end,
  input  logic  take_ref,
  input  logic  fast_q,
  input  logic  io_sel,
  output slot_e kind
);
  slot_e nxt;

  always_comb begin
    if (take_ref)              nxt = SLOT_REFRESH;
    else if (fast_q && !io_sel) nxt = SLOT_FAST;
    else                       nxt = SLOT_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        kind <= SLOT_SLOW;
    else if (slot_end) kind <= nxt;
  end

  // R7: an I/O select at the boundary never yields a fast slot
  assert_io_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && io_sel) |=> (kind != SLOT_FAST));

  // R6: the slot type holds for the whole slot
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(kind));
endmodule

// File: rtl/dsc_clock_ctl.sv
module dsc_clock_ctl
  import dsc_pkg::*;
#(
  parameter int PH_BITS  = 3,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int MODE_ADR = 48,
  parameter int ROW_W    = 8,
  parameter int PER_LINE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              line_stb,
  input  logic              io_sel,
  output logic              phi0,
  output logic              cpu_bus,
  output logic              display_en,
  output logic              ref_act,
  output logic [ROW_W-1:0]  ref_addr
);
  localparam int SLOW_BIT = PH_BITS - 1;
  localparam int FAST_BIT = PH_BITS - 2;

  logic [PH_BITS-1:0] ph;
  logic               slot_end;
  logic               fast_q;
  logic               take;
  slot_e              kind;

  dsc_phase #(.PH_BITS(PH_BITS)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph), .slot_end(slot_end)
  );

  dsc_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADR(MODE_ADR)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fast_q(fast_q), .rd_data(rd_data)
  );

  dsc_refresh #(.ROW_W(ROW_W), .PER_LINE(PER_LINE)) u_ref (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .slot_end(slot_end),
    .in_ref_slot(kind == SLOT_REFRESH), .take(take), .row(ref_addr)
  );

  dsc_slot_sel u_sel (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .take_ref(take),
    .fast_q(fast_q), .io_sel(io_sel), .kind(kind)
  );

  assign phi0       = (kind == SLOT_FAST) ? ph[FAST_BIT] : ph[SLOW_BIT];
  assign cpu_bus    = (kind == SLOT_FAST) || ph[SLOW_BIT];
  assign ref_act    = (kind == SLOT_REFRESH) && !ph[SLOW_BIT];
  assign display_en = !fast_q;

  // R10: no single-cycle high or low phase
  assert_min_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi0) |=> phi0);
  assert_min_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi0) |=> !phi0);

  // R8: refresh never overlaps processor ownership
  assert_ref_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_act |-> !cpu_bus);
endmodule

// File: tb/tb_dsc_clock_ctl.sv
module tb_dsc_clock_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       line_stb = 1'b0;
  logic       io_sel = 1'b0;
  logic       phi0, cpu_bus, display_en, ref_act;
  logic [7:0] ref_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsc_clock_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .line_stb(line_stb),
    .io_sel(io_sel), .phi0(phi0), .cpu_bus(cpu_bus),
    .display_en(display_en), .ref_act(ref_act), .ref_addr(ref_addr)
  );

  // reference model built from the requirements (0 slow,1 fast,2 refresh)
  int m_ph, m_kind, m_mode, m_pend, m_row;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_kind <= 0; m_mode <= 0; m_pend <= 0; m_row <= 0;
    end else begin
      if (wr_en && wr_addr == 6'd48) m_mode <= int'(wr_data[0]);
      if (line_stb) m_pend <= 5;
      else if (m_ph == 7 && m_pend != 0) m_pend <= m_pend - 1;
      if (m_ph == 7) begin
        if (m_kind == 2) m_row <= (m_row + 1) % 256;
        if (m_pend != 0) m_kind <= 2;
        else if (m_mode == 1 && !io_sel) m_kind <= 1;
        else m_kind <= 0;
      end
      m_ph <= (m_ph + 1) % 8;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  int run_len = 0;
  logic last_phi = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_phi, e_bus, e_ref;
      e_phi = (m_kind == 1) ? ((m_ph >> 1) & 1) : ((m_ph >> 2) & 1);
      e_bus = (m_kind == 1) ? 1 : ((m_ph >> 2) & 1);
      e_ref = (m_kind == 2 && m_ph < 4) ? 1 : 0;
      if (m_kind == 1) begin
        chk("R3 phi0", int'(phi0), e_phi);
        chk("R3 cpu_bus", int'(cpu_bus), e_bus);
      end else begin
        chk("R2 phi0", int'(phi0), e_phi);
        chk("R2 cpu_bus", int'(cpu_bus), e_bus);
      end
      chk("R8 ref_act", int'(ref_act), e_ref);
      chk("R9 ref_addr", int'(ref_addr), m_row);
      chk("R5 display_en", int'(display_en), 1 - m_mode);
      chk("R4 rd_data", int'(rd_data), 254 + m_mode);
      if (phi0 != last_phi) begin
        chk("R10 phase length", (run_len >= 2) ? 1 : 0, 1);
        run_len = 1;
      end else run_len++;
      last_phi = phi0;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ph(int p);
    while (m_ph != p) @(negedge clk);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rd_data", int'(rd_data), 254);
    chk("R1 display_en", int'(display_en), 1);
    chk("R1 ref_addr", int'(ref_addr), 0);
    chk("R1 ref_act", int'(ref_act), 0);
    chk("R1 phi0", int'(phi0), 0);
    rst_n = 1'b1;
    repeat (32) @(negedge clk);

    // R6: write fast mode mid-slot; the current slot stays slow
    wait_ph(2);
    wr(48, 8'h01);
    chk("R5 display off", int'(display_en), 0);
    wait_ph(6);
    chk("R6 still slow", int'(cpu_bus), 1);
    wait_ph(1);
    chk("R6 now fast", int'(cpu_bus), 1);
    repeat (40) @(negedge clk);

    // R4: foreign addresses leave the mode bit alone
    wr(47, 8'h00);
    wr(16, 8'h00);
    chk("R4 foreign write", int'(rd_data), 255);
    repeat (16) @(negedge clk);

    // R7: io_sel held across boundaries forces slow slots
    for (int k = 0; k < 4; k++) begin
      wait_ph(5);
      io_sel = (k % 2 == 0);
      wait_ph(1);
      io_sel = 1'b0;
      chk("R7 slot owner", int'(cpu_bus), (k % 2 == 0) ? 0 : 1);
    end
    repeat (16) @(negedge clk);

    // R8/R9: refresh bursts in fast mode, enough lines to wrap the row
    for (int ln = 0; ln < 53; ln++) begin
      if (ln == 30) wr(48, 8'h00);
      wait_ph(2);
      line_stb = 1'b1;
      @(negedge clk);
      line_stb = 1'b0;
      repeat (56) @(negedge clk);
    end
    chk("R9 row wrapped", int'(ref_addr), 265 % 256);
    chk("R5 display back on", int'(display_en), 1);
    repeat (16) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule